// File: doc/BRIEF.md
# Wide Time-Base Counter with Snapshot Read

This block keeps a 40-bit time base that counts up by one on each cycle where a tick-enable strobe is high and counting has been switched on. The strobe is made elsewhere at about 983.04 kHz. The block never raises an interrupt. Software reaches the count through two 32-bit words on a simple single-cycle register bus.

The count is wider than one bus word, so it takes two accesses to read. Reading the low word returns count bits 31:0. The same read copies the upper count bits into a shadow byte. A read of the high word that follows returns that shadow byte, not the live upper bits. The two halves therefore come from one instant, even when a carry crosses bit 32 between the two accesses. The high word also holds the switch that turns counting on. The counter width and the split point between the two words are parameters.

Top module: `tsc40_timebase`

## Requirements
- R1: After reset the count is zero, counting is off and the shadow byte is zero, so both the low word and the high word read as zero.
- R2: While counting is on, the count rises by one on every clock edge where `tick_en` is high. It stays the same on edges where `tick_en` is low. It wraps from all-ones to zero.
- R3: While counting is off, `tick_en` has no effect on the count.
- R4: A read at offset 0x60 returns count bits 31:0 as they stand in that cycle.
- R5: A read at offset 0x60 copies count bits 39:32 from the same cycle into the shadow byte. A read at offset 0x64 returns the shadow byte in bits 7:0.
- R6: A read at offset 0x64 changes no state. Repeated high reads return the same shadow byte until the next read at offset 0x60.
- R7: A write at offset 0x64 sets the counting switch from write-data bit 8 (1 = counting on). The high word returns the switch in bit 8, and its bits 31:9 read as zero.
- R8: Writes at offset 0x60 are ignored. They change neither the count nor the switch.
- R9: A read at any offset other than 0x60 or 0x64 returns zero, and writes there change nothing. `bus_rdata` is zero whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count strobe, one clock wide per tick |
| bus_sel | input | 1 | Access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |

## Verification
The assertions take for granted that each bus access lasts exactly one clock cycle and is sampled at that cycle's edge. They also take for granted that `tick_en` is a clean synchronous strobe. The bench drives every input half a cycle away from the active edge and holds an access for one cycle only, so it stays within these limits. A second instance with a 16-bit counter split at bit 8 lets the stimulus reach the shadow capture and the wrap from all-ones to zero. Random stimulus mixes ticks, reads and writes at valid and invalid offsets.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int unsigned BUS_W     = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam logic [ADDR_W-1:0] OFS_LOW  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_HIGH = 8'h64;
    localparam int unsigned RUN_BIT   = 8;
endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
    parameter int unsigned CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_en,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run && tick_en) begin
            st_d.count = st_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    // R2: one step per enabled tick, modulo 2^CNT_W
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en) |=> (count == $past(count) + CNT_W'(1)));
    // R2, R3: no tick or counting off leaves the count alone
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick_en) |=> $stable(count));
endmodule

// File: rtl/tsc_regs.sv
module tsc_regs
    import tsc_pkg::*;
#(
    parameter int unsigned CNT_W = 40,
    parameter int unsigned LOW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_run,
    input  logic [CNT_W-1:0]  count,
    output logic              run,
    output logic [BUS_W-1:0]  bus_rdata
);
    localparam int unsigned HI_W = CNT_W - LOW_W;

    typedef struct packed {
        logic            run;
        logic [HI_W-1:0] shadow;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic rd_low, rd_high, wr_high;

    assign rd_low  = bus_sel && !bus_wr && (bus_addr == OFS_LOW);
    assign rd_high = bus_sel && !bus_wr && (bus_addr == OFS_HIGH);
    assign wr_high = bus_sel &&  bus_wr && (bus_addr == OFS_HIGH);

    always_comb begin
        st_d      = st_q;
        bus_rdata = '0;
        if (rd_low) begin
            st_d.shadow            = count[CNT_W-1:LOW_W];
            bus_rdata[LOW_W-1:0]   = count[LOW_W-1:0];
        end
        if (wr_high) begin
            st_d.run = wr_run;
        end
        if (rd_high) begin
            bus_rdata[HI_W-1:0]    = st_q.shadow;
            bus_rdata[RUN_BIT]     = st_q.run;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run = st_q.run;

    // R5: a low read captures the upper count bits of that cycle
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_low |=> (st_q.shadow == $past(count[CNT_W-1:LOW_W])));
    // R6: only a low read moves the shadow
    a_r6_shadow_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_low |=> $stable(st_q.shadow));
    // R7: unused upper bits of the high word stay zero
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_high |-> (bus_rdata[BUS_W-1:RUN_BIT+1] == '0));
    // R8, R9: only a high write changes the switch
    a_r8_run_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_high |=> $stable(run));
    // R9: no read, no data
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_low || rd_high) |-> (bus_rdata == '0));
endmodule

// File: rtl/tsc40_timebase.sv
module tsc40_timebase
    import tsc_pkg::*;
#(
    parameter int unsigned CNT_W = 40,
    parameter int unsigned LOW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic             run;
    logic [CNT_W-1:0] count;
    logic             unused_wdata;

    assign unused_wdata = ^{bus_wdata[BUS_W-1:RUN_BIT+1], bus_wdata[RUN_BIT-1:0]};

    tsc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick_en (tick_en),
        .count   (count)
    );

    tsc_regs #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .wr_run    (bus_wdata[RUN_BIT]),
        .count     (count),
        .run       (run),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: tb/tb_tsc40_timebase.sv
module tb_tsc40_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_big, rd_small;

    int checks = 0;
    int errors = 0;

    // bench models: big = 40-bit/32 split, small = 16-bit/8 split
    longint unsigned cnt_b = 0, cnt_s = 0;
    longint unsigned sh_b = 0, sh_s = 0;
    bit run_m = 0;

    always #5 clk = ~clk;

    tsc40_timebase dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_big)
    );

    tsc40_timebase #(.CNT_W(16), .LOW_W(8)) dut_small (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rd_small)
    );

    function automatic longint unsigned exp_rd(input logic [7:0] a,
            input longint unsigned c, input longint unsigned sh, input bit r,
            input int lw);
        if (a == 8'h60) return c & ((64'd1 << lw) - 1);
        if (a == 8'h64) return sh | (longint'(r) << 8);
        return 0;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input string tag, input logic [31:0] got,
                         input longint unsigned want);
        checks++;
        if (got !== 32'(want)) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, 32'(want));
        end
    endtask

    // one bus cycle: drive after the falling edge, check, then advance models
    task automatic cyc(input string tag, input bit sel, input bit wr,
                       input logic [7:0] a, input logic [31:0] wd, input bit tk);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd; tick_en = tk;
        #1;
        if (sel && !wr) begin
            check({tag, " big"},   rd_big,   exp_rd(a, cnt_b, sh_b, run_m, 32));
            check({tag, " small"}, rd_small, exp_rd(a, cnt_s, sh_s, run_m, 8));
        end else if (!sel) begin
            checks++;
            if (rd_big !== 0 || rd_small !== 0) begin
                errors++;
                $display("FAIL R9 idle: actual %h/%h expected 0", rd_big, rd_small);
            end
        end
        @(posedge clk);
        if (sel && !wr && a == 8'h60) begin
            sh_b = cnt_b >> 32;
            sh_s = cnt_s >> 8;
        end
        if (run_m && tk) begin
            cnt_b = (cnt_b + 1) & ((64'd1 << 40) - 1);
            cnt_s = (cnt_s + 1) & 64'hFFFF;
        end
        if (sel && wr && a == 8'h64) run_m = wd[8];
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc("R2", 1'b0, 1'b0, 8'h00, 32'h0, 1'b1);
    endtask

    initial begin
        int cyc_cnt = 0;
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 190000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc_cnt);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0040));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cyc("R1", 1, 0, 8'h60, 0, 0);
        cyc("R1", 1, 0, 8'h64, 0, 0);
        // R3 counting off ignores ticks
        ticks(5);
        cyc("R3", 1, 0, 8'h60, 0, 0);
        // R7 switch on, readback, upper bits zero despite ones written
        cyc("R7", 1, 1, 8'h64, 32'hFFFF_FFFF, 0);
        cyc("R7", 1, 0, 8'h64, 0, 0);
        // R2 counting
        ticks(10);
        cyc("R2", 1, 0, 8'h60, 0, 0);
        repeat (4) cyc("R2", 0, 0, 8'h00, 0, 0);
        cyc("R2", 1, 0, 8'h60, 0, 1);
        cyc("R4", 1, 0, 8'h60, 0, 1);
        // R8 write to low word ignored
        cyc("R8", 1, 1, 8'h60, 32'h0000_0000, 1);
        cyc("R8", 1, 0, 8'h64, 0, 0);
        cyc("R8", 1, 0, 8'h60, 0, 0);
        // R9 other offsets
        cyc("R9", 1, 0, 8'h68, 0, 0);
        cyc("R9", 1, 1, 8'h68, 32'h0, 0);
        cyc("R9", 1, 0, 8'h64, 0, 0);
        // R5 capture of upper bits (small instance crosses its split)
        ticks(300);
        cyc("R5", 1, 0, 8'h60, 0, 1);
        cyc("R5", 1, 0, 8'h64, 0, 1);
        // R6 repeated high reads keep the shadow while counting on
        ticks(600);
        cyc("R6", 1, 0, 8'h64, 0, 1);
        cyc("R6", 1, 0, 8'h64, 0, 1);
        // R3 switch off mid-run
        cyc("R3", 1, 1, 8'h64, 32'h0, 1);
        ticks(7);
        cyc("R3", 1, 0, 8'h60, 0, 1);
        cyc("R3", 1, 0, 8'h64, 0, 0);
        // R2 wrap of the small counter
        cyc("R2", 1, 1, 8'h64, 32'h100, 0);
        ticks(65536);
        cyc("R2 wrap", 1, 0, 8'h60, 0, 0);
        cyc("R2 wrap", 1, 0, 8'h64, 0, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] pick = 2'($urandom_range(0, 3));
            logic [7:0] a = (pick == 0) ? 8'h60 : (pick == 1) ? 8'h64 :
                            (pick == 2) ? 8'h60 : 8'($urandom_range(0, 255));
            bit sel = ($urandom_range(0, 3) != 0);
            bit wr  = ($urandom_range(0, 7) == 0);
            logic [31:0] wd = $urandom;
            if (wr && a == 8'h64) wd[8] = ($urandom_range(0, 3) != 0);
            cyc(a == 8'h60 ? "R4" : a == 8'h64 ? "R6" : "R9", sel, wr, a, wd,
                1'($urandom_range(0, 1)));
        end
        finish_run();
    end
endmodule